// File: doc/BRIEF.md
# Saturating Add/Subtract Unit

This unit computes 32-bit signed saturating sums and differences. It also has two doubling forms: the second operand is first doubled with saturation, then added to or taken from the first operand with saturation. Any result that leaves the signed 32-bit range is clamped to the nearest representable extreme. A sticky saturation flag records that clamping happened at some point.

The flag is never cleared by arithmetic. Software state reaches it through a status-word write port: a write loads the flag from bit 27 of the written word, the position just below the overflow flag in the status word. An operation is presented with a valid strobe. The result and the flag are registered on the next clock edge, and the result holds its value until the next valid operation.

The unit has no multi-cycle control. It is one register stage behind two identical saturating adder stages, with an enumerated operation code decoded by a unique case.

Top module: `sat_alu`

## Requirements
- R1: The operation code selects the function: 2'b00 add (A+B), 2'b01 subtract (A-B), 2'b10 double-add (A+2B), 2'b11 double-subtract (A-2B). Operands and results are two's-complement signed 32-bit values. An in-range add returns the exact sum.
- R2: A result above 0x7FFFFFFF is clamped to 0x7FFFFFFF. A result below 0x80000000 (as a signed value) is clamped to 0x80000000.
- R3: An in-range subtract returns the exact difference A-B, and an out-of-range subtract saturates as in R2.
- R4: The doubling forms clamp 2B to the signed range before it is used, and they set the flag when that clamping occurs.
- R5: The doubling forms saturate the second stage, A plus or minus the clamped 2B, again, and they set the flag when that stage clamps.
- R6: Any clamping in an operation sets the sticky flag. No arithmetic operation clears it.
- R7: A status write loads the flag from bit 27 of the written word. If a valid operation comes in the same cycle, the new flag is the written bit ORed with that operation's clamp indication.
- R8: The result and the flag change on the clock edge after the valid strobe. Without a valid strobe the result holds.
- R9: Reset (rst_n low) sets the result to 0 and the flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Operation code (see R1) |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| stat_we_i | input | 1 | Status-word write enable |
| stat_wdata_i | input | 32 | Status word; bit 27 is the flag |
| result_o | output | 32 | Registered result |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
A status write and a valid operation can land in the same cycle, and the flag must then take the written bit ORed with the operation's clamp. The bench drives writes that clear the flag together with operations that clamp and with operations that do not, and it also scatters writes at random through a long operand stream rich in extremes. A behavioural model using 64-bit integer arithmetic predicts the result and the flag each cycle, and the outputs are compared on every clock.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_DADD = 2'b10,
        OP_DSUB = 2'b11
    } sat_op_e;
endpackage

// File: rtl/sat_stage.sv
module sat_stage #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o,
    output logic         clamp_o
);
    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] raw;
    logic         ovf;

    always_comb begin
        raw = sub_i ? (a_i - b_i) : (a_i + b_i);
        if (sub_i)
            ovf = (a_i[W-1] != b_i[W-1]) && (raw[W-1] != a_i[W-1]);
        else
            ovf = (a_i[W-1] == b_i[W-1]) && (raw[W-1] != a_i[W-1]);
        y_o     = ovf ? (a_i[W-1] ? NEG_MIN : POS_MAX) : raw;
        clamp_o = ovf;
    end
endmodule

// File: rtl/sat_flag.sv
module sat_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic wbit_i,
    input  logic set_i,
    output logic sat_o
);
    logic sat_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sat_q <= 1'b0;
        else
            sat_q <= (we_i ? wbit_i : sat_q) | set_i;
    end

    assign sat_o = sat_q;

    // R6
    no_arith_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sat_q) |-> $past(we_i));

    // R6
    clamp_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> sat_q);
endmodule

// File: rtl/sat_alu.sv
module sat_alu #(
    parameter int W       = 32,
    parameter int SAT_BIT = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         stat_we_i,
    input  logic [W-1:0] stat_wdata_i,
    output logic [W-1:0] result_o,
    output logic         sat_o
);
    import sat_alu_pkg::*;

    localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

    sat_op_e      op;
    logic         dbl_en, sub_en;
    logic [W-1:0] dbl_val, second_op, sum_val;
    logic         dbl_clamp, sum_clamp, any_clamp;
    logic [W-1:0] result_q;
    logic         unused_wbits;

    assign op = sat_op_e'(op_i);
    assign unused_wbits = ^{stat_wdata_i[W-1:SAT_BIT+1], stat_wdata_i[SAT_BIT-1:0]};

    always_comb begin
        unique case (op)
            OP_ADD:  begin dbl_en = 1'b0; sub_en = 1'b0; end
            OP_SUB:  begin dbl_en = 1'b0; sub_en = 1'b1; end
            OP_DADD: begin dbl_en = 1'b1; sub_en = 1'b0; end
            OP_DSUB: begin dbl_en = 1'b1; sub_en = 1'b1; end
            default: begin dbl_en = 1'b0; sub_en = 1'b0; end
        endcase
    end

    sat_stage #(.W(W)) u_dbl (
        .a_i(opb_i), .b_i(opb_i), .sub_i(1'b0),
        .y_o(dbl_val), .clamp_o(dbl_clamp)
    );

    assign second_op = dbl_en ? dbl_val : opb_i;

    sat_stage #(.W(W)) u_sum (
        .a_i(opa_i), .b_i(second_op), .sub_i(sub_en),
        .y_o(sum_val), .clamp_o(sum_clamp)
    );

    assign any_clamp = valid_i && (sum_clamp || (dbl_en && dbl_clamp));

    always_ff @(posedge clk) begin
        if (!rst_n)
            result_q <= '0;
        else if (valid_i)
            result_q <= sum_val;
    end

    sat_flag u_flag (
        .clk(clk), .rst_n(rst_n),
        .we_i(stat_we_i), .wbit_i(stat_wdata_i[SAT_BIT]),
        .set_i(any_clamp), .sat_o(sat_o)
    );

    assign result_o = result_q;

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_i) |-> $stable(result_q));

    // R2
    clamp_extreme_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && sum_clamp) |=> (result_q == POS_MAX || result_q == NEG_MIN));

    // R7
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we_i && !valid_i) |=> (sat_o == $past(stat_wdata_i[SAT_BIT])));

    // R4
    dbl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && dbl_en && dbl_clamp) |=> sat_o);
endmodule

// File: tb/sat_alu_bench.sv
module sat_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] opa_i = '0, opb_i = '0;
    logic        stat_we_i = 1'b0;
    logic [31:0] stat_wdata_i = '0;
    logic [31:0] result_o;
    logic        sat_o;

    int checks = 0, errors = 0, cycles = 0;
    logic [31:0] exp_res = '0;
    bit          exp_sat = 1'b0;

    localparam longint MAXV = 64'sd2147483647;
    localparam longint MINV = -64'sd2147483648;

    always #4 clk = ~clk;

    sat_alu u_sat_alu (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .stat_we_i(stat_we_i),
        .stat_wdata_i(stat_wdata_i), .result_o(result_o), .sat_o(sat_o)
    );

    function automatic void model(input logic [1:0] op, input logic [31:0] a,
                                  input logic [31:0] b,
                                  output logic [31:0] r, output bit c);
        longint sa = longint'($signed(a));
        longint d  = longint'($signed(b));
        longint x;
        c = 1'b0;
        if (op[1]) begin
            d = 2 * d;
            if (d > MAXV) begin d = MAXV; c = 1'b1; end
            if (d < MINV) begin d = MINV; c = 1'b1; end
        end
        x = op[0] ? sa - d : sa + d;
        if (x > MAXV) begin x = MAXV; c = 1'b1; end
        if (x < MINV) begin x = MINV; c = 1'b1; end
        r = x[31:0];
    endfunction

    task automatic check(input string req);
        checks++;
        if (result_o !== exp_res) begin
            errors++;
            $display("FAIL %s result actual=%h expected=%h", req, result_o, exp_res);
        end
        checks++;
        if (sat_o !== exp_sat) begin
            errors++;
            $display("FAIL %s flag actual=%b expected=%b", req, sat_o, exp_sat);
        end
    endtask

    // one cycle: drive at negedge, model, sample at next negedge
    task automatic step(input bit v, input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, input bit we, input bit wbit,
                        input string req);
        logic [31:0] r;
        bit c;
        valid_i = v; op_i = op; opa_i = a; opb_i = b;
        stat_we_i = we; stat_wdata_i = we ? (32'h1 << 27) * wbit | 32'hF000_0000 : 32'h0;
        model(op, a, b, r, c);
        @(posedge clk);
        if (v) exp_res = r;
        exp_sat = (we ? wbit : exp_sat) | (v & c);
        @(negedge clk);
        valid_i = 1'b0; stat_we_i = 1'b0;
        check(req);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 9))
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'h4000_0000;
            3: return 32'hC000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'h0000_0001;
            default: return $urandom;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog R8 actual=%0d cycles expected<20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after reset");
        step(1, 2'b00, 32'd100, 32'hFFFF_FFF6, 0, 0, "R1 add");
        step(0, 2'b00, 32'd5, 32'd5, 0, 0, "R8 hold");
        step(1, 2'b01, 32'd7, 32'd20, 0, 0, "R3 sub");
        step(1, 2'b00, 32'h7FFF_FFF0, 32'h100, 0, 0, "R2 add pos clamp");
        step(1, 2'b00, 32'd1, 32'd1, 0, 0, "R6 sticky");
        step(0, 2'b00, 32'd0, 32'd0, 1, 0, "R7 write clear");
        step(1, 2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, "R2 add neg clamp");
        step(0, 2'b00, 32'd0, 32'd0, 1, 0, "R7 write clear");
        step(1, 2'b01, 32'h8000_0000, 32'd1, 0, 0, "R3 sub neg clamp");
        step(0, 2'b00, 32'd0, 32'd0, 1, 0, "R7 write clear");
        step(1, 2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R3 sub pos clamp");
        step(0, 2'b00, 32'd0, 32'd0, 1, 0, "R7 write clear");
        step(1, 2'b10, 32'h8000_0000, 32'h4000_0000, 0, 0, "R4 dbl clamp only");
        step(0, 2'b00, 32'd0, 32'd0, 1, 0, "R7 write clear");
        step(1, 2'b10, 32'h0000_0010, 32'h4000_0000, 0, 0, "R5 dadd both clamp");
        step(0, 2'b00, 32'd0, 32'd0, 1, 0, "R7 write clear");
        step(1, 2'b11, 32'd50, 32'd20, 0, 0, "R1 dsub in range");
        step(1, 2'b11, 32'h0000_0000, 32'hC000_0000, 0, 0, "R5 dsub clamp");
        step(0, 2'b00, 32'd0, 32'd0, 1, 1, "R7 write set");
        step(1, 2'b00, 32'd3, 32'd4, 1, 0, "R7 write clear with plain op");
        step(1, 2'b00, 32'h7FFF_FFFF, 32'd1, 1, 0, "R7 write clear with clamp op");
        step(1, 2'b01, 32'd9, 32'd2, 1, 1, "R7 write set with plain op");
        for (int i = 0; i < 400; i++) begin
            bit w = ($urandom_range(0, 5) == 0);
            step($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)), pick(), pick(),
                 w, 1'($urandom_range(0, 1)), "R6 random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule